// File: doc/BRIEF.md
# Synchronous Two-Clock Bus Memory Target

This block answers a processor bus whose transfers end on a synchronous termination strobe rather than a late acknowledge. The master puts an address on the bus and pulls the address strobe low at the start of a transfer. The target decodes the transfer and drives its active-low termination strobe. On a read it returns a word from a local array of registers. On a write it stores the word the master supplies. With no wait states a transfer takes two clocks. The first is the address clock, and termination is signalled before it ends. The second is the data clock, where read data is driven or write data is captured.

A wait-state selector can hold off termination for slower memory. A value of W adds W clocks. Termination then comes in clock 1+W and the data clock moves to 2+W. Termination always comes before write data appears on the bus, so the write is taken in the data clock and never when termination is given. Transfers can follow each other with no idle clock in between. If the master releases the strobe early, the transfer is dropped and leaves no trace.

Top module: `sbt_target`

## Requirements
- R1: While reset is held and right after it, `term_n` is 1 and `data_oe` is 0. Reset clears every word of the array to zero, and a later read returns 0.
- R2: With `wait_sel` = 0, `term_n` is 0 during the address clock, which is the clock in which `as_n` is first sampled low while the target is idle. The data clock follows at once, so the transfer lasts two clocks.
- R3: `term_n` is low for exactly one clock per transfer. It is never low in a clock where `as_n` is 1.
- R4: With `wait_sel` = W (0 to 3), `term_n` stays high for W clocks after the address clock and goes low in clock 1+W. The data clock is clock 2+W.
- R5: `data_oe` is 1 only in the data clock of a read (`rd_wr` = 1). In that clock `data_out` holds the addressed word. At every other time `data_oe` is 0 and `data_out` is 0.
- R6: A write (`rd_wr` = 0) stores the value on `data_in` in the data clock. Values present on `data_in` during the address clock or the wait clocks are not stored.
- R7: A new transfer may begin in the clock right after a data clock, with `as_n` held low throughout, and it is terminated on the same schedule as one that starts after an idle clock.
- R8: If `as_n` goes high before the data clock, no termination is given after that point and no word is written. If `as_n` goes high in the data clock, no word is written and `data_oe` stays 0.
- R9: The word index is the low 4 bits of `bus_addr`. The upper address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Transfer address, valid from the address clock |
| as_n | input | 1 | Active-low address strobe, held low for the whole transfer |
| rd_wr | input | 1 | 1 = read, 0 = write |
| wait_sel | input | WS_W (2) | Wait states to add before termination, sampled in the address clock |
| data_in | input | DATA_W (32) | Write data from the master, taken in the data clock |
| data_out | output | DATA_W (32) | Read data, non-zero only while `data_oe` is 1 |
| data_oe | output | 1 | Drive enable for the shared data bus |
| term_n | output | 1 | Active-low synchronous termination strobe |

## Verification
The properties take for granted that the master holds `rd_wr` steady while `as_n` is low within one transfer. They also assume `as_n` is high or well defined during reset. The bench drives every input on the falling edge and keeps `rd_wr` and `bus_addr` fixed from the address clock through the data clock. It changes them only at a transfer boundary, including when transfers run back to back. During the address and wait clocks the bench places the bit-inverted write word on `data_in`, so a capture made too early would show up in a later read.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_DATA = 2'd2
   } sbt_state_e;
endpackage

// File: rtl/sbt_ctrl.sv
module sbt_ctrl
   import sbt_pkg::*;
#(
   parameter int IDX_W    = 4,
   parameter int MAX_WAIT = 3,
   parameter int WS_W     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             as_n,
   input  logic             rd_wr,
   input  logic [IDX_W-1:0] idx_in,
   input  logic [WS_W-1:0]  wait_sel,
   output logic             term,
   output logic             rd_phase,
   output logic             wr_phase,
   output logic [IDX_W-1:0] idx_q
);
   sbt_state_e      state_q, state_d;
   logic [WS_W-1:0] cnt_q, cnt_d;
   logic [WS_W-1:0] ws_eff;
   logic            rd_q;
   logic            start;

   // clamp the requested wait count to the supported maximum
   assign ws_eff = (int'(wait_sel) > MAX_WAIT) ? WS_W'(MAX_WAIT) : wait_sel;
   assign start  = rst_n && !as_n && (state_q == ST_IDLE);

   always_comb begin
      state_d  = state_q;
      cnt_d    = cnt_q;
      term     = 1'b0;
      rd_phase = 1'b0;
      wr_phase = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               if (ws_eff == '0) begin
                  term    = 1'b1;
                  state_d = ST_DATA;
               end else begin
                  cnt_d   = ws_eff;
                  state_d = ST_WAIT;
               end
            end
         end
         ST_WAIT: begin
            if (as_n) begin
               state_d = ST_IDLE;
            end else if (cnt_q == WS_W'(1)) begin
               term    = 1'b1;
               state_d = ST_DATA;
            end else begin
               cnt_d = cnt_q - WS_W'(1);
            end
         end
         ST_DATA: begin
            state_d = ST_IDLE;
            if (!as_n) begin
               rd_phase = rd_q;
               wr_phase = !rd_q;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         rd_q    <= 1'b0;
         idx_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         if (start) begin
            rd_q  <= rd_wr;
            idx_q <= idx_in;
         end
      end
   end
endmodule

// File: rtl/sbt_regfile.sv
module sbt_regfile #(
   parameter int WORDS  = 16,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] word_q [WORDS];

   for (genvar g = 0; g < WORDS; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q[g] <= '0;
         end else if (we && (int'(idx) == g)) begin
            word_q[g] <= wdata;
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < WORDS; k++) begin
         if (int'(idx) == k) rdata = word_q[k];
      end
   end
endmodule

// File: rtl/sbt_target.sv
module sbt_target #(
   parameter int ADDR_W        = 8,
   parameter int DATA_W        = 32,
   parameter int WORDS         = 16,
   parameter int MAX_WAIT      = 3,
   parameter bit ZERO_IDLE_OUT = 1'b1,
   localparam int IDX_W        = $clog2(WORDS),
   localparam int WS_W         = (MAX_WAIT < 2) ? 1 : $clog2(MAX_WAIT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              as_n,
   input  logic              rd_wr,
   input  logic [WS_W-1:0]   wait_sel,
   input  logic [DATA_W-1:0] data_in,
   output logic [DATA_W-1:0] data_out,
   output logic              data_oe,
   output logic              term_n
);
   if (WORDS < 2 || (1 << IDX_W) != WORDS) begin : g_bad_words
      $error("sbt_target: WORDS must be a power of two, at least 2");
   end
   if (ADDR_W < IDX_W) begin : g_bad_addr
      $error("sbt_target: ADDR_W too narrow for WORDS");
   end
   if (MAX_WAIT < 0) begin : g_bad_wait
      $error("sbt_target: MAX_WAIT must not be negative");
   end

   logic             term;
   logic             rd_phase;
   logic             wr_phase;
   logic [IDX_W-1:0] idx_q;
   logic [DATA_W-1:0] rdata;

   sbt_ctrl #(
      .IDX_W    (IDX_W),
      .MAX_WAIT (MAX_WAIT),
      .WS_W     (WS_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .as_n     (as_n),
      .rd_wr    (rd_wr),
      .idx_in   (bus_addr[IDX_W-1:0]),
      .wait_sel (wait_sel),
      .term     (term),
      .rd_phase (rd_phase),
      .wr_phase (wr_phase),
      .idx_q    (idx_q)
   );

   sbt_regfile #(
      .WORDS  (WORDS),
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_phase),
      .idx   (idx_q),
      .wdata (data_in),
      .rdata (rdata)
   );

   assign term_n  = !term;
   assign data_oe = rd_phase;

   if (ZERO_IDLE_OUT) begin : g_zero_out
      assign data_out = rd_phase ? rdata : '0;
   end else begin : g_raw_out
      assign data_out = rdata;
   end
endmodule

// File: rtl/sbt_target_chk.sv
module sbt_target_chk (
   input logic clk,
   input logic rst_n,
   input logic as_n,
   input logic rd_wr,
   input logic data_oe,
   input logic term_n
);
   // R1: quiet outputs while reset is held
   p_quiet_in_reset_r1: assert property (@(posedge clk)
      !rst_n |-> (term_n && !data_oe));

   // R3: termination only under an active strobe
   p_term_needs_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !term_n |-> !as_n);

   // R3: termination lasts a single clock
   p_term_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !term_n |=> term_n);

   // R4: the data clock comes directly after termination
   p_data_after_term_r4: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> $past(!term_n));

   // R5: drive only for a read under an active strobe
   p_oe_read_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> (!as_n && rd_wr));

   // R2: a terminated read drives in the next clock unless the strobe drops
   p_read_follows_term_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!term_n && rd_wr) |=> (data_oe || as_n));
endmodule

bind sbt_target sbt_target_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .as_n    (as_n),
   .rd_wr   (rd_wr),
   .data_oe (data_oe),
   .term_n  (term_n)
);

// File: tb/sbt_target_tb.sv
module sbt_target_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 11;
   // {rd[40], ws[39:38], addr[37:32], data[31:0]}
   localparam logic [40:0] VEC [NV] = '{
      {1'b1, 2'd0, 6'h03, 32'h0000_0000},
      {1'b0, 2'd0, 6'h03, 32'hA5A5_0003},
      {1'b1, 2'd0, 6'h03, 32'h0000_0000},
      {1'b0, 2'd1, 6'h07, 32'h1111_2222},
      {1'b0, 2'd2, 6'h0F, 32'h3333_4444},
      {1'b0, 2'd3, 6'h00, 32'h5555_6666},
      {1'b1, 2'd3, 6'h0F, 32'h0000_0000},
      {1'b1, 2'd1, 6'h27, 32'h0000_0000},
      {1'b1, 2'd2, 6'h00, 32'h0000_0000},
      {1'b0, 2'd0, 6'h13, 32'hDEAD_BEEF},
      {1'b1, 2'd0, 6'h03, 32'h0000_0000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        as_n = 1'b1;
   logic        rd_wr = 1'b1;
   logic [1:0]  wait_sel = '0;
   logic [31:0] data_in = '0;
   logic [31:0] data_out;
   logic        data_oe;
   logic        term_n;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [31:0] exp_mem [16];

   always #(CLK_PERIOD/2) clk = ~clk;

   sbt_target u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .as_n     (as_n),
      .rd_wr    (rd_wr),
      .wait_sel (wait_sel),
      .data_in  (data_in),
      .data_out (data_out),
      .data_oe  (data_oe),
      .term_n   (term_n)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic xfer(input logic rd, input logic [1:0] ws,
                       input logic [7:0] a, input logic [31:0] d,
                       input bit b2b, input string rtag);
      for (int c = 0; c <= int'(ws); c++) begin
         @(negedge clk);
         as_n = 1'b0; rd_wr = rd; bus_addr = a; wait_sel = ws; data_in = ~d;
         #1;
         chk(term_n == ((c == int'(ws)) ? 1'b0 : 1'b1),
             (c == 0 && b2b) ? "R7" : ((ws == 2'd0) ? "R2" : "R4"),
             {31'd0, term_n}, {31'd0, (c != int'(ws))});
         chk(!data_oe, "R5", {31'd0, data_oe}, 32'd0);
      end
      @(negedge clk);
      data_in = d;
      #1;
      chk(term_n, "R3", {31'd0, term_n}, 32'd1);
      if (rd) begin
         chk(data_oe, "R5", {31'd0, data_oe}, 32'd1);
         chk(data_out == exp_mem[a[3:0]],
             (rtag != "") ? rtag : ((a[7:4] != 4'd0) ? "R9" : "R5"),
             data_out, exp_mem[a[3:0]]);
      end else begin
         chk(!data_oe && data_out == '0, "R5", data_out, 32'd0);
         exp_mem[a[3:0]] = d;
      end
   endtask

   task automatic idle_clock();
      @(negedge clk);
      as_n = 1'b1;
      #1;
      chk(term_n && !data_oe, "R3", {30'd0, term_n, data_oe}, 32'd2);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) exp_mem[i] = '0;
      // R1: held in reset
      repeat (2) begin
         @(negedge clk);
         #1;
         chk(term_n && !data_oe, "R1", {30'd0, term_n, data_oe}, 32'd2);
      end
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(term_n && !data_oe, "R1", {30'd0, term_n, data_oe}, 32'd2);

      // vector table, transfers back to back
      for (int v = 0; v < NV; v++) begin
         xfer(VEC[v][40], VEC[v][39:38], {2'b00, VEC[v][37:32]},
              VEC[v][31:0], v > 0, (v == 0) ? "R1" : "");
      end
      idle_clock();

      // R6: write with wait states, early data differs from the stored value
      xfer(1'b0, 2'd2, 8'h0A, 32'hCAFE_0A0A, 1'b0, "");
      xfer(1'b1, 2'd0, 8'h0A, 32'h0, 1'b1, "R6");
      idle_clock();

      // R8: strobe released during a wait clock
      @(negedge clk);
      as_n = 1'b0; rd_wr = 1'b0; bus_addr = 8'h05; wait_sel = 2'd2; data_in = 32'h55;
      #1;
      chk(term_n, "R8", {31'd0, term_n}, 32'd1);
      @(negedge clk);
      as_n = 1'b1;
      #1;
      chk(term_n, "R8", {31'd0, term_n}, 32'd1);
      @(negedge clk);
      #1;
      chk(term_n && !data_oe, "R8", {30'd0, term_n, data_oe}, 32'd2);
      xfer(1'b1, 2'd0, 8'h05, 32'h0, 1'b0, "R8");
      idle_clock();

      // R8: strobe released in the data clock
      @(negedge clk);
      as_n = 1'b0; rd_wr = 1'b0; bus_addr = 8'h06; wait_sel = 2'd0; data_in = 32'h0;
      #1;
      chk(!term_n, "R8", {31'd0, term_n}, 32'd0);
      @(negedge clk);
      as_n = 1'b1; data_in = 32'h66;
      #1;
      chk(!data_oe && term_n, "R8", {30'd0, term_n, data_oe}, 32'd2);
      xfer(1'b1, 2'd0, 8'h06, 32'h0, 1'b0, "R8");
      idle_clock();

      // R1: reset during operation clears the array
      @(negedge clk);
      rst_n = 1'b0; as_n = 1'b0;
      #1;
      chk(term_n && !data_oe, "R1", {30'd0, term_n, data_oe}, 32'd2);
      @(negedge clk);
      as_n = 1'b1;
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 16; i++) exp_mem[i] = '0;
      xfer(1'b1, 2'd1, 8'h03, 32'h0, 1'b0, "R1");
      xfer(1'b1, 2'd0, 8'h0A, 32'h0, 1'b1, "R1");
      idle_clock();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule